// File: doc/BRIEF.md
# Bit-Serial Word Equality Comparator

This block decides whether two words are equal by looking at them one bit pair per clock. Rather than laying out one comparison cell per bit position and chaining their equal signals, it keeps a single cell and a flip-flop. The flip-flop holds the running "still equal" value. On every clock that accepts a bit, the cell combines that value with the current bit pair. The register then feeds the result back as the cell's input for the next bit.

A comparison starts when the active-low synchronous reset is held low for a clock. That clock presets the running flag to "equal" and clears the bit count. Bit pairs are accepted only on clocks where the valid strobe is high, so the source may pause between bits. After `WORD_LEN` accepted bits the done output rises. From then on the result and the done flag are frozen until the next reset. A reset clock that also carries a valid bit starts the new word with that bit as its first bit.

Top module: `bitserial_eq_cmp`

## Requirements
- R1: An accepted bit pair whose two bits differ drives `isEqual` to 0 on the clock after it is sampled, even if `isEqual` was 1.
- R2: An accepted bit pair whose two bits are equal leaves `isEqual` unchanged on the following clock.
- R3: Once `isEqual` is 0 it stays 0 on every later clock until a clock with `rstN` low.
- R4: A clock with `rstN` low and `bitValid` low makes `isEqual` 1 and `wordDone` 0 on the next clock.
- R5: `wordDone` is 0 until the clock after the `WORD_LEN`-th accepted bit of the word, and 1 from that clock on (default `WORD_LEN` = 8).
- R6: A clock with `bitValid` low changes neither output, whatever values `xBit` and `yBit` carry.
- R7: While `wordDone` is 1, valid bits are ignored, and both outputs hold their values until a clock with `rstN` low.
- R8: A clock with `rstN` low and `bitValid` high starts a new word whose first bit is that bit pair. The next clock shows `isEqual` equal to 1 if and only if the two bits match, and `WORD_LEN`-1 further accepted bits raise `wordDone`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset; starts a new comparison |
| bitValid | input | 1 | High on clocks that carry a bit pair |
| xBit | input | 1 | Current bit of the first word |
| yBit | input | 1 | Current bit of the second word |
| isEqual | output | 1 | Registered running equality result |
| wordDone | output | 1 | Registered flag: `WORD_LEN` bits have been accepted |

## Verification
Both outputs are registered directly from the sampling edge. The effect of a bit pair, a reset or a stall is therefore due exactly one clock after the edge that samples it, with no further pipeline stage. The bench drives inputs on the falling edge. Its behavioural model advances on the same rising edge that the design samples. Design and model are compared a short delay after that edge, so the value checked is always the one just registered. The directed checks sample one clock after the stimulus they target: the word's final bit for done, a mismatch for the flag, and a reset for the preset.

// File: rtl/bitserial_eq_cmp_pkg.sv
package bitserial_eq_cmp_pkg;

  // Strobes sent from the control section to the datapath each clock.
  typedef struct packed {
    logic startWord;  // this clock opens a fresh word
    logic takeBit;    // this clock's bit pair enters the comparison
  } cmpStrobe_t;

endpackage

// File: rtl/cmp_cell.sv
// One stage of an equality chain: passes "equal" on only if the
// incoming chain value is equal and both bits agree.
module cmp_cell (
  input  logic eqIn,
  input  logic aBit,
  input  logic bBit,
  output logic eqOut
);
  always_comb eqOut = eqIn & ~(aBit ^ bBit);
endmodule

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import bitserial_eq_cmp_pkg::*;
(
  input  logic       clk,
  input  cmpStrobe_t ctl,
  input  logic       xBit,
  input  logic       yBit,
  output logic       eqFlag
);
  logic chainIn;
  logic chainOut;

  // A word-opening clock feeds the cell with "equal" instead of the register.
  always_comb chainIn = ctl.startWord ? 1'b1 : eqFlag;

  cmp_cell u_cell (
    .eqIn  (chainIn),
    .aBit  (xBit),
    .bBit  (yBit),
    .eqOut (chainOut)
  );

  always_ff @(posedge clk) begin
    if (ctl.takeBit)        eqFlag <= chainOut;
    else if (ctl.startWord) eqFlag <= 1'b1;
  end
endmodule

// File: rtl/cmp_control.sv
module cmp_control
  import bitserial_eq_cmp_pkg::*;
#(
  parameter int WORD_LEN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  output cmpStrobe_t ctl,
  output logic       doneFlag
);
  localparam int CNT_W = $clog2(WORD_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_LEN - 1);
  localparam logic ONE_BIT_WORD = (WORD_LEN == 1);

  logic [CNT_W-1:0] bitCount;

  always_comb begin
    ctl.startWord = ~rstN;
    ctl.takeBit   = bitValid & (~rstN | ~doneFlag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCount <= bitValid ? CNT_W'(1) : '0;
      doneFlag <= bitValid & ONE_BIT_WORD;
    end else if (ctl.takeBit) begin
      bitCount <= bitCount + CNT_W'(1);
      doneFlag <= (bitCount == LAST_IDX);
    end
  end
endmodule

// File: rtl/bitserial_eq_cmp.sv
module bitserial_eq_cmp
  import bitserial_eq_cmp_pkg::*;
#(
  parameter int WORD_LEN = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitValid,
  input  logic xBit,
  input  logic yBit,
  output logic isEqual,
  output logic wordDone
);
  cmpStrobe_t ctl;

  cmp_control #(.WORD_LEN(WORD_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (bitValid),
    .ctl      (ctl),
    .doneFlag (wordDone)
  );

  cmp_datapath u_dp (
    .clk    (clk),
    .ctl    (ctl),
    .xBit   (xBit),
    .yBit   (yBit),
    .eqFlag (isEqual)
  );
endmodule

// File: rtl/bitserial_eq_cmp_chk.sv
module bitserial_eq_cmp_chk #(
  parameter int WORD_LEN = 8
) (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic xBit,
  input logic yBit,
  input logic isEqual,
  input logic wordDone
);
  localparam int SEEN_W = $clog2(WORD_LEN + 1) + 1;
  logic [SEEN_W-1:0] seenBits;

  // Independent tally of accepted bits, saturating at the word length.
  always_ff @(posedge clk) begin
    if (!rstN)                                     seenBits <= bitValid ? SEEN_W'(1) : '0;
    else if (bitValid && seenBits < SEEN_W'(WORD_LEN)) seenBits <= seenBits + SEEN_W'(1);
  end

  a_r1_mismatch_clears: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !wordDone && (xBit != yBit)) |=> !isEqual);

  a_r2_match_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !wordDone && (xBit == yBit)) |=> $stable(isEqual));

  a_r3_sticky_low: assert property (@(posedge clk) disable iff (!rstN)
    !isEqual |=> !isEqual);

  a_r4_reset_preset: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN && !bitValid) |-> (isEqual && !wordDone));

  a_r5_done_count: assert property (@(posedge clk) disable iff (!rstN)
    wordDone == (seenBits == SEEN_W'(WORD_LEN)));

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> ($stable(isEqual) && $stable(wordDone)));

  a_r7_done_frozen: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |=> (wordDone && $stable(isEqual)));

  a_r8_reset_takes_bit: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN && bitValid) |-> (isEqual == ($past(xBit) == $past(yBit))));
endmodule

bind bitserial_eq_cmp bitserial_eq_cmp_chk #(.WORD_LEN(WORD_LEN)) u_chk (.*);

// File: tb/tb_bitserial_eq_cmp.sv
`timescale 1ns/1ps
module tb_bitserial_eq_cmp;
  localparam int WORD_LEN = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitValid = 1'b0;
  logic xBit = 1'b0;
  logic yBit = 1'b0;
  logic isEqual;
  logic wordDone;

  int checks = 0;
  int errors = 0;

  int refEq = 1;
  int refCnt = 0;
  int refDone = 0;
  bit modelLive = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bitserial_eq_cmp #(.WORD_LEN(WORD_LEN)) dut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid),
    .xBit(xBit), .yBit(yBit), .isEqual(isEqual), .wordDone(wordDone)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: advances on the same edge the design samples,
  // compared 2 ns later once the registered outputs have settled.
  always @(posedge clk) begin
    if (!rstN) begin
      refEq = 1; refCnt = 0; refDone = 0; modelLive = 1'b1;
    end
    if (bitValid && refDone == 0) begin
      if (xBit != yBit) refEq = 0;
      refCnt++;
      if (refCnt == WORD_LEN) refDone = 1;
    end
    #2;
    if (modelLive) begin
      check("R2 model isEqual", isEqual, refEq[0]);
      check("R5 model wordDone", wordDone, refDone[0]);
    end
  end

  task automatic drive(logic r, logic v, logic x, logic y);
    @(negedge clk);
    rstN = r; bitValid = v; xBit = x; yBit = y;
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  initial begin
    // reset, no valid bit
    drive(0, 0, 0, 0); drive(0, 0, 0, 0); drive(1, 0, 0, 0); #2;
    check("R4 reset isEqual", isEqual, 1'b1);
    check("R4 reset wordDone", wordDone, 1'b0);

    // equal word with stalls carrying mismatching idle data
    for (int i = 0; i < WORD_LEN; i++) begin
      drive(1, 1, i[0], i[0]);
      drive(1, 0, 1, 0);
      settle();
      check("R6 idle mismatch ignored", isEqual, 1'b1);
      if (i < WORD_LEN - 1) check("R5 not done early", wordDone, 1'b0);
    end
    check("R5 done after last bit", wordDone, 1'b1);

    // bits after done are ignored
    drive(1, 1, 1, 0); settle();
    check("R7 isEqual held after done", isEqual, 1'b1);
    check("R7 wordDone held", wordDone, 1'b1);

    // new word with a mismatch at bit 3
    drive(0, 0, 0, 0); drive(1, 0, 0, 0); #2;
    check("R4 second reset", isEqual, 1'b1);
    for (int i = 0; i < WORD_LEN; i++) begin
      drive(1, 1, 1'b1, (i == 3) ? 1'b0 : 1'b1);
      settle();
      if (i == 3) check("R1 mismatch clears", isEqual, 1'b0);
      if (i > 3)  check("R3 stays low", isEqual, 1'b0);
    end
    check("R5 done second word", wordDone, 1'b1);

    // reset carrying a mismatching first bit
    drive(0, 1, 0, 1); settle();
    check("R8 first bit counted", isEqual, 1'b0);
    check("R8 not done yet", wordDone, 1'b0);
    for (int i = 1; i < WORD_LEN; i++) drive(1, 1, 0, 0);
    settle();
    check("R8 done after WORD_LEN-1 more", wordDone, 1'b1);
    check("R3 low through word", isEqual, 1'b0);

    // reset carrying a matching first bit
    drive(0, 1, 1, 1); settle();
    check("R8 matching first bit", isEqual, 1'b1);

    // random traffic, checked against the model each clock
    for (int i = 0; i < 600; i++) begin
      drive(($urandom_range(0, 19) != 0), ($urandom_range(0, 3) != 0),
            $urandom_range(0, 1), ($urandom_range(0, 7) == 0) ? $urandom_range(0, 1) : xBit);
    end
    drive(1, 0, 0, 0); settle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule